// File: doc/BRIEF.md
# Three-Pair Motor PWM Modulator with Deadband and Fault Shutdown

This block drives three high/low output pairs for a three-phase motor bridge from one shared 12-bit period counter. The counter runs in edge-aligned mode, counting up and wrapping to zero, or in center-aligned mode, counting up to the reload value and back down. Each channel compares the count with its own duty value. In complementary mode the low side is the inverse of the high side. A programmable deadband keeps both switches of a pair off for a number of clock cycles after every edge. In independent mode all six outputs follow their own duty values and no deadband is inserted.

One configuration bit sets the off level of all high-side outputs and another sets it for all low-side outputs. The on level is the inverse of the off level. A per-channel polarity bit inverts that channel's modulator. Each output can be forced to its off level. Fault inputs can be masked one by one. An unmasked fault latches a flag and forces every output to its off level. Each source is released either automatically when it deasserts or only by a software clear pulse. When enabled, the block emits a one-cycle ADC trigger at the end of every period.

Top module: `mcpwm_top`

## Requirements
- R1: During and right after reset, every output is at its off level. adc_trig is 0 and fault_flags is 0.
- R2: In edge-aligned mode (center_mode=0), the period is reload+1 cycles. The high-side modulator of a channel is on for `duty` cycles of each period, that is while the count is below duty.
- R3: In center-aligned mode (center_mode=1), the period is 2*reload cycles. The modulator is on for 2*duty-1 cycles per period, for 1 <= duty <= reload.
- R4: In complementary mode (indep_mode=0), the low side is the inverse of the high-side modulator. After every modulator edge, both outputs stay off for `deadband` cycles. The two outputs of a pair are never both on.
- R5: In independent mode (indep_mode=1), the low side is on while the count is below its own duty_lo value, and no deadband is applied.
- R6: High-side outputs sit at off_lvl_hi when off and at its inverse when on. Low-side outputs use off_lvl_lo the same way.
- R7: chan_pol[i]=1 inverts channel i's modulator. The high side is then on for period minus duty cycles and starts each period off.
- R8: force_hi[i] or force_lo[i] holds that one output at its off level. The other outputs are not affected.
- R9: An unmasked asserted fault_in bit sets its fault_flags bit at the next clock edge. From that same edge, all six outputs are at their off levels. A masked fault sets no flag and leaves the outputs modulating.
- R10: For a source with fault_sw=0, the flag clears at the first edge where the input is low. Modulation resumes only when all flags are clear.
- R11: For a source with fault_sw=1, the flag stays set after the input deasserts. It clears only at an edge where fault_clear is 1 and the input is low.
- R12: With trig_en=1, adc_trig pulses high for one cycle per period, one cycle after the period end. With trig_en=0 it stays low.
- R13: With enable=0, the counter is held at zero and all outputs are at their off levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the counter and the modulators |
| center_mode | input | 1 | 1 selects center-aligned, 0 selects edge-aligned |
| indep_mode | input | 1 | 1 selects six independent channels, 0 selects complementary pairs |
| reload | input | 12 | Period limit of the counter |
| duty_hi | input | 36 | Three 12-bit duty values for the high sides (channel i at bits 12i+11:12i) |
| duty_lo | input | 36 | Three 12-bit duty values for the low sides, used in independent mode |
| deadband | input | 8 | Dead time in clock cycles |
| chan_pol | input | 3 | Per-channel modulator inversion |
| off_lvl_hi | input | 1 | Off level of all high-side outputs |
| off_lvl_lo | input | 1 | Off level of all low-side outputs |
| force_hi | input | 3 | Force each high-side output off |
| force_lo | input | 3 | Force each low-side output off |
| fault_in | input | 2 | Fault inputs, active high |
| fault_mask | input | 2 | 1 masks (ignores) the fault source |
| fault_sw | input | 2 | 1 selects software release, 0 selects automatic release |
| fault_clear | input | 1 | Software release pulse |
| trig_en | input | 1 | Enable the ADC trigger |
| out_hi | output | 3 | High-side outputs |
| out_lo | output | 3 | Low-side outputs |
| adc_trig | output | 1 | One-cycle end-of-period trigger |
| fault_flags | output | 2 | Latched fault per source |

## Verification
The hardest case is the software-release fault path. A source must be raised and then dropped, and the outputs must still stay off until a separate clear pulse arrives. The stimulus therefore holds the fault, releases it, waits many cycles while checking that the flag stays set and the outputs stay at their off levels, and only then pulses fault_clear. Deadband behaviour is checked without sampling individual edges. On-cycles are counted over whole periods, so the dead time shows up as an exact shortfall against the duty value on each side. A second source is used to show that one automatic source clearing does not restart the outputs while another source is still latched.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
   typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_t;
endpackage

// File: rtl/mcpwm_cnt.sv
module mcpwm_cnt #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          center_mode,
   input  logic [CW-1:0] reload,
   input  logic          trig_en,
   output logic [CW-1:0] cnt,
   output logic          adc_trig
);
   import mcpwm_pkg::*;

   cnt_dir_t dir;
   logic     period_end;

   always_comb begin
      if (!enable)          period_end = 1'b0;
      else if (center_mode) period_end = (dir == DIR_DOWN) && (cnt == '0);
      else                  period_end = (cnt >= reload);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         dir      <= DIR_UP;
         adc_trig <= 1'b0;
      end else begin
         adc_trig <= trig_en & period_end;
         if (!enable) begin
            cnt <= '0;
            dir <= DIR_UP;
         end else if (!center_mode) begin
            dir <= DIR_UP;
            cnt <= (cnt >= reload) ? '0 : cnt + 1'b1;
         end else if (dir == DIR_UP) begin
            if (cnt >= reload) begin
               dir <= DIR_DOWN;
               cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            if (cnt == '0) begin
               dir <= DIR_UP;
               cnt <= (reload != '0) ? CW'(1) : '0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R2
   edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !center_mode) |=> (cnt == '0 || cnt == CW'($past(cnt) + 1'b1)));

   // R12
   trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_trig && reload != '0) |=> !adc_trig);
endmodule

// File: rtl/mcpwm_pair.sv
module mcpwm_pair #(
   parameter int CW  = 12,
   parameter int DBW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CW-1:0]  cnt,
   input  logic [CW-1:0]  duty_hi,
   input  logic [CW-1:0]  duty_lo,
   input  logic [DBW-1:0] deadband,
   input  logic           pol,
   input  logic           indep,
   input  logic           run,
   input  logic           force_hi,
   input  logic           force_lo,
   input  logic           off_hi,
   input  logic           off_lo,
   output logic           out_hi,
   output logic           out_lo
);
   logic           mod_hi_n, mod_lo_n;
   logic           mod_hi_q, mod_lo_q;
   logic [DBW-1:0] dcnt;
   logic           db_done, on_hi, on_lo;

   assign mod_hi_n = (cnt < duty_hi) ^ pol;
   assign mod_lo_n = (cnt < duty_lo) ^ pol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mod_hi_q <= 1'b0;
         mod_lo_q <= 1'b0;
         dcnt     <= '0;
      end else begin
         mod_hi_q <= mod_hi_n;
         mod_lo_q <= mod_lo_n;
         if (mod_hi_n != mod_hi_q)  dcnt <= '0;
         else if (dcnt < deadband)  dcnt <= dcnt + 1'b1;
      end
   end

   always_comb begin
      db_done = (dcnt >= deadband);
      on_hi   = indep ? mod_hi_q : (mod_hi_q & db_done);
      on_lo   = indep ? mod_lo_q : (~mod_hi_q & db_done);
      out_hi  = (on_hi & run & ~force_hi) ? ~off_hi : off_hi;
      out_lo  = (on_lo & run & ~force_lo) ? ~off_lo : off_lo;
   end

   // R4
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!indep && deadband != '0 && ($rose(mod_hi_q) || $fell(mod_hi_q))) |-> (!on_hi && !on_lo));

   // R4
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !indep |-> !((out_hi != off_hi) && (out_lo != off_lo)));
endmodule

// File: rtl/mcpwm_fault.sv
module mcpwm_fault #(
   parameter int NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] fault_in,
   input  logic [NF-1:0] fault_mask,
   input  logic [NF-1:0] fault_sw,
   input  logic          fault_clear,
   output logic [NF-1:0] flags,
   output logic          active
);
   logic [NF-1:0] eff;

   assign eff    = fault_in & ~fault_mask;
   assign active = |flags;

   for (genvar i = 0; i < NF; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n)                          flags[i] <= 1'b0;
         else if (eff[i])                     flags[i] <= 1'b1;
         else if (!fault_sw[i] || fault_clear) flags[i] <= 1'b0;
      end

      // R11
      sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && fault_sw[i] && !fault_clear) |=> flags[i]);
   end

   // R9
   masked_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & fault_mask) == '0) |=> ((flags & $past(fault_mask)) == '0));
endmodule

// File: rtl/mcpwm_top.sv
module mcpwm_top #(
   parameter int NCH = 3,
   parameter int CW  = 12,
   parameter int DBW = 8,
   parameter int NF  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               center_mode,
   input  logic               indep_mode,
   input  logic [CW-1:0]      reload,
   input  logic [NCH*CW-1:0]  duty_hi,
   input  logic [NCH*CW-1:0]  duty_lo,
   input  logic [DBW-1:0]     deadband,
   input  logic [NCH-1:0]     chan_pol,
   input  logic               off_lvl_hi,
   input  logic               off_lvl_lo,
   input  logic [NCH-1:0]     force_hi,
   input  logic [NCH-1:0]     force_lo,
   input  logic [NF-1:0]      fault_in,
   input  logic [NF-1:0]      fault_mask,
   input  logic [NF-1:0]      fault_sw,
   input  logic               fault_clear,
   input  logic               trig_en,
   output logic [NCH-1:0]     out_hi,
   output logic [NCH-1:0]     out_lo,
   output logic               adc_trig,
   output logic [NF-1:0]      fault_flags
);
   logic [CW-1:0] cnt;
   logic          fault_act;
   logic          run;

   initial begin
      assert (CW >= 2 && CW <= 16) else $error("counter width out of range");
      assert (DBW >= 1 && DBW <= CW) else $error("deadband width out of range");
      assert (NCH >= 1 && NF >= 1) else $error("channel and fault counts must be positive");
   end

   assign run = enable & ~fault_act;

   mcpwm_cnt #(.CW(CW)) cnt_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .center_mode(center_mode),
      .reload(reload), .trig_en(trig_en), .cnt(cnt), .adc_trig(adc_trig)
   );

   mcpwm_fault #(.NF(NF)) fault_i (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .fault_mask(fault_mask),
      .fault_sw(fault_sw), .fault_clear(fault_clear), .flags(fault_flags),
      .active(fault_act)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      mcpwm_pair #(.CW(CW), .DBW(DBW)) pair_i (
         .clk(clk), .rst_n(rst_n), .cnt(cnt),
         .duty_hi(duty_hi[c*CW +: CW]), .duty_lo(duty_lo[c*CW +: CW]),
         .deadband(deadband), .pol(chan_pol[c]), .indep(indep_mode), .run(run),
         .force_hi(force_hi[c]), .force_lo(force_lo[c]),
         .off_hi(off_lvl_hi), .off_lo(off_lvl_lo),
         .out_hi(out_hi[c]), .out_lo(out_lo[c])
      );
   end

   // R9
   fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(fault_in & ~fault_mask)) |=> (out_hi == {NCH{off_lvl_hi}} && out_lo == {NCH{off_lvl_lo}}));

   // R13
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (out_hi == {NCH{off_lvl_hi}} && out_lo == {NCH{off_lvl_lo}}));
endmodule

// File: tb/mcpwm_top_tb_top.sv
module mcpwm_top_tb_top;
   localparam int NCH = 3, CW = 12, DBW = 8, NF = 2;
   localparam int NV = 4;
   localparam int V_CTR [NV] = '{0, 0, 1, 1};
   localparam int V_REL [NV] = '{99, 99, 50, 40};
   localparam int V_DUT [NV] = '{30, 60, 20, 10};
   localparam int V_DB  [NV] = '{5, 0, 3, 10};

   logic clk = 1'b0;
   logic rst_n;
   logic enable, center_mode, indep_mode;
   logic [CW-1:0] reload;
   logic [NCH*CW-1:0] duty_hi, duty_lo;
   logic [DBW-1:0] deadband;
   logic [NCH-1:0] chan_pol, force_hi, force_lo;
   logic off_lvl_hi, off_lvl_lo;
   logic [NF-1:0] fault_in, fault_mask, fault_sw;
   logic fault_clear, trig_en;
   logic [NCH-1:0] out_hi, out_lo;
   logic adc_trig;
   logic [NF-1:0] fault_flags;

   int checks = 0, errors = 0;
   int h0, l0, h2, trg, ovl;

   always #2 clk = ~clk;

   mcpwm_top #(.NCH(NCH), .CW(CW), .DBW(DBW), .NF(NF)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .center_mode(center_mode),
      .indep_mode(indep_mode), .reload(reload), .duty_hi(duty_hi), .duty_lo(duty_lo),
      .deadband(deadband), .chan_pol(chan_pol), .off_lvl_hi(off_lvl_hi),
      .off_lvl_lo(off_lvl_lo), .force_hi(force_hi), .force_lo(force_lo),
      .fault_in(fault_in), .fault_mask(fault_mask), .fault_sw(fault_sw),
      .fault_clear(fault_clear), .trig_en(trig_en), .out_hi(out_hi), .out_lo(out_lo),
      .adc_trig(adc_trig), .fault_flags(fault_flags)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int per_len(input int c, input int r);
      return c ? 2 * r : r + 1;
   endfunction

   function automatic int on_len(input int c, input int d);
      return c ? 2 * d - 1 : d;
   endfunction

   task automatic setup(input int c, input int r, input int d, input int db);
      @(negedge clk);
      enable = 1'b0;
      repeat (2) @(negedge clk);
      center_mode = c[0];
      reload      = CW'(r);
      duty_hi     = {NCH{CW'(d)}};
      deadband    = DBW'(db);
      enable      = 1'b1;
      repeat (2 * per_len(c, r) + 300) @(negedge clk);
   endtask

   task automatic measure(input int n);
      h0 = 0; l0 = 0; h2 = 0; trg = 0; ovl = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         h0  += int'(out_hi[0]);
         l0  += int'(out_lo[0]);
         h2  += int'(out_hi[2]);
         trg += int'(adc_trig);
         ovl += int'(out_hi[0] & out_lo[0]);
      end
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; center_mode = 1'b0; indep_mode = 1'b0;
      reload = '0; duty_hi = '0; duty_lo = '0; deadband = '0; chan_pol = '0;
      off_lvl_hi = 1'b1; off_lvl_lo = 1'b0; force_hi = '0; force_lo = '0;
      fault_in = '0; fault_mask = '0; fault_sw = '0; fault_clear = 1'b0; trig_en = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state with high-side off level 1
      chk("R1 out_hi", int'(out_hi), 7);
      chk("R1 out_lo", int'(out_lo), 0);
      chk("R1 adc_trig", int'(adc_trig), 0);
      chk("R1 fault_flags", int'(fault_flags), 0);
      rst_n = 1'b1;
      off_lvl_hi = 1'b0;

      // R2 R3 R4 R12 table walk
      for (int v = 0; v < NV; v++) begin
         int p, o;
         p = per_len(V_CTR[v], V_REL[v]);
         o = on_len(V_CTR[v], V_DUT[v]);
         setup(V_CTR[v], V_REL[v], V_DUT[v], V_DB[v]);
         measure(4 * p);
         chk(V_CTR[v] ? "R3 hi0 on" : "R2 hi0 on", h0, 4 * (o - V_DB[v]));
         chk("R4 lo0 on", l0, 4 * (p - o - V_DB[v]));
         chk(V_CTR[v] ? "R3 hi2 on" : "R2 hi2 on", h2, 4 * (o - V_DB[v]));
         chk("R12 trig count", trg, 4);
         chk("R4 overlap", ovl, 0);
      end

      // R7 polarity on channel 0 only
      chan_pol = 3'b001;
      setup(0, 99, 30, 0);
      measure(400);
      chk("R7 hi0 inverted", h0, 280);
      chk("R7 lo0 inverted", l0, 120);
      chk("R7 hi2 normal", h2, 120);
      chan_pol = '0;

      // R6 off levels 1: zeros count as on
      off_lvl_hi = 1'b1; off_lvl_lo = 1'b1;
      setup(0, 99, 30, 5);
      measure(400);
      chk("R6 hi0 low cycles", 400 - h0, 100);
      chk("R6 lo0 low cycles", 400 - l0, 260);
      off_lvl_hi = 1'b0; off_lvl_lo = 1'b0;

      // R5 independent mode
      indep_mode = 1'b1;
      duty_lo = {NCH{CW'(10)}};
      setup(0, 99, 30, 5);
      measure(400);
      chk("R5 hi0 own duty", h0, 120);
      chk("R5 lo0 own duty", l0, 40);
      indep_mode = 1'b0;

      // R8 force high side of channel 0
      setup(0, 99, 30, 5);
      force_hi = 3'b001;
      measure(400);
      chk("R8 forced hi0", h0, 0);
      chk("R8 lo0 untouched", l0, 260);
      chk("R8 hi2 untouched", h2, 100);
      force_hi = '0;

      // R12 trigger disabled
      trig_en = 1'b0;
      measure(400);
      chk("R12 trig disabled", trg, 0);
      trig_en = 1'b1;

      // R9 masked fault
      fault_mask = 2'b01; fault_in = 2'b01;
      measure(400);
      chk("R9 masked flag", int'(fault_flags), 0);
      chk("R9 masked hi0", h0, 100);
      fault_in = '0; fault_mask = '0;

      // R9 unmasked fault, R10 automatic release
      @(negedge clk);
      fault_in = 2'b01;
      @(negedge clk);
      chk("R9 flag set", int'(fault_flags), 1);
      chk("R9 outputs off", int'({out_hi, out_lo}), 0);
      measure(200);
      chk("R9 held off", h0 + l0 + h2, 0);
      fault_in = 2'b00;
      @(negedge clk);
      chk("R10 auto release flag", int'(fault_flags), 0);
      repeat (200) @(negedge clk);
      measure(400);
      chk("R10 resumed hi0", h0, 100);

      // R10 second source still latched blocks restart
      fault_in = 2'b11;
      @(negedge clk);
      fault_in = 2'b10; fault_sw = 2'b10;
      repeat (3) @(negedge clk);
      chk("R10 one source left", int'(fault_flags), 2);
      fault_in = 2'b00;
      measure(200);
      chk("R11 sw flag holds", int'(fault_flags), 2);
      chk("R11 outputs held off", h0 + l0 + h2, 0);
      fault_clear = 1'b1;
      @(negedge clk);
      fault_clear = 1'b0;
      chk("R11 cleared by software", int'(fault_flags), 0);
      repeat (200) @(negedge clk);
      measure(400);
      chk("R11 resumed hi0", h0, 100);
      fault_sw = '0;

      // R13 disabled
      enable = 1'b0;
      measure(200);
      chk("R13 disabled outputs", h0 + l0 + h2, 0);
      chk("R13 disabled trig", trg, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule